// File: doc/BRIEF.md
# Serial Receiver Sleep and Wake-Up Controller

This block holds the control side of an asynchronous serial receiver that can be put to sleep. Software asks for sleep with a one-cycle request. The hardware then waits for one of two wake conditions, chosen by a mode input. The first is a line that stays at one for a whole frame time. The second is a received word that carries an address mark in its most significant bit. While the receiver sleeps, incoming words are not loaded and do not touch the status flags. The block also owns the receive status flags: data ready, overrun, idle line, noise and framing error. All of them are held clear while the receiver is disabled. The block combines the flags into one receive interrupt request.

Bit sampling and data shifting happen outside the block. A bit-time strobe with the sampled line value arrives on one input pair. A word strobe with the assembled data and its noise and framing indications arrives on another. The frame-length input selects 8-bit or 9-bit words. A frame is 10 bit times for 8-bit words and 11 for 9-bit words.

The controller is a three-state machine. ST_OFF means the receiver is disabled. ST_AWAKE is normal reception. ST_SLEEP waits for a wake event. The transitions are:

- OFF to AWAKE when enabled.
- OFF to SLEEP when enabled with a sleep request.
- AWAKE to SLEEP on a sleep request.
- SLEEP to AWAKE on idle-line or address-mark wake, depending on the mode.
- AWAKE or SLEEP to OFF when the enable drops.

Top module: `rxwk_ctrl`

## Requirements
- R1: `rx_pad_input` equals `re` at all times.
- R2: A word strobe while awake sets `rdrf` in the next cycle. In that same cycle, `rx_data`, `nf` and `fe` take the word's data, noise and framing values.
- R3: A word strobe while `rdrf` is 1, with no clear request in the same cycle, sets `ovr` in the next cycle and leaves `rx_data` unchanged.
- R4: While awake, `idle` is set in the cycle after 10 consecutive one-valued bit strobes (`long_frame`=0) or 11 of them (`long_frame`=1). A zero-valued bit strobe restarts the count. The count saturates, so the flag is set only once per idle stretch.
- R5: A `rwu_set` pulse while enabled makes `sleeping` 1 in the next cycle. It also restarts the consecutive-ones count from zero.
- R6: With `wake_sel`=0, a sleeping receiver wakes (`sleeping` goes to 0) in the cycle after the 10th or 11th consecutive one following sleep entry. That wake does not set `idle`.
- R7: With `wake_sel`=1, a sleeping receiver wakes on a word strobe whose mark bit is 1. The mark bit is `word_data[7]` when `long_frame`=0 and `word_data[8]` when `long_frame`=1. That word is loaded and sets `rdrf` like a normal word. A word without the mark leaves the receiver asleep.
- R8: While asleep, word strobes that do not wake the receiver change none of `rdrf`, `ovr` and `rx_data`, and idle stretches do not set `idle`.
- R9: While `re` is 0, `rdrf`, `ovr`, `idle`, `nf`, `fe` and `sleeping` are all 0 from the next cycle on, and word strobes are ignored.
- R10: A `rdrf_clr` pulse clears `rdrf`, `ovr`, `nf` and `fe`. An `idle_clr` pulse clears `idle`. A word strobe in the same cycle as `rdrf_clr` is loaded, leaving `rdrf` at 1 and `ovr` at 0.
- R11: `rx_irq` is 1 exactly when (`rie` and (`rdrf` or `ovr`)) or (`ilie` and `idle`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| re | input | 1 | Receiver enable |
| rwu_set | input | 1 | One-cycle sleep request from software |
| wake_sel | input | 1 | Wake mode: 0 idle line, 1 address mark |
| long_frame | input | 1 | 0: 8-bit words, 10-bit frame; 1: 9-bit words, 11-bit frame |
| rie | input | 1 | Data-ready/overrun interrupt enable |
| ilie | input | 1 | Idle-line interrupt enable |
| bit_stb | input | 1 | One pulse per received bit time |
| bit_val | input | 1 | Sampled line value at the bit strobe |
| word_valid | input | 1 | Received-word strobe |
| word_data | input | 9 | Received word, bit 8 used only for 9-bit words |
| word_nf | input | 1 | Noise seen in the received word |
| word_fe | input | 1 | Framing error in the received word |
| rdrf_clr | input | 1 | Clears data-ready, overrun, noise and framing flags |
| idle_clr | input | 1 | Clears the idle flag |
| rx_pad_input | output | 1 | Forces the RX pad to input direction |
| sleeping | output | 1 | Receiver asleep |
| rdrf | output | 1 | Received data ready |
| ovr | output | 1 | Overrun |
| idle | output | 1 | Idle line detected |
| nf | output | 1 | Noise flag |
| fe | output | 1 | Framing error flag |
| rx_data | output | 9 | Last loaded word |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Two collisions get the most attention. The first is a word strobe in the same cycle as a data-ready clear. The bench drives both strobes in one cycle while `rdrf` is set and expects the new word to be loaded with no overrun. The second is the address-marked word that wakes a sleeping receiver. Here the wake and the load happen at the same edge. The bench checks, one cycle later, that `sleeping` has dropped and that `rdrf` and `rx_data` already show that word. It also checks that unmarked words and idle stretches before it left everything untouched.

// File: rtl/rxwk_pkg.sv
package rxwk_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_AWAKE = 2'd1,
        ST_SLEEP = 2'd2
    } wake_state_t;

endpackage

// File: rtl/rxwk_idle_counter.sv
module rxwk_idle_counter #(
    parameter int SHORT_BITS = 10,
    parameter int LONG_BITS  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic long_frame,
    input  logic bit_stb,
    input  logic bit_val,
    output logic full_hit
);
    localparam int CW = $clog2(LONG_BITS + 1);
    localparam logic [CW-1:0] TGT_S = CW'(SHORT_BITS);
    localparam logic [CW-1:0] TGT_L = CW'(LONG_BITS);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic [CW-1:0] ones_cnt;
    logic [CW-1:0] target;

    always_comb begin
        target   = long_frame ? TGT_L : TGT_S;
        full_hit = bit_stb && bit_val && !clear && (ones_cnt == target - ONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_cnt <= '0;
        end else if (clear) begin
            ones_cnt <= '0;
        end else if (bit_stb) begin
            if (!bit_val) begin
                ones_cnt <= '0;
            end else if (ones_cnt < target) begin
                ones_cnt <= ones_cnt + ONE;
            end
        end
    end
endmodule

// File: rtl/rxwk_sleep_fsm.sv
module rxwk_sleep_fsm
    import rxwk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic re,
    input  logic rwu_set,
    input  logic wake_sel,
    input  logic idle_hit,
    input  logic addr_hit,
    output logic sleeping,
    output logic awake,
    output logic arm
);
    wake_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (re) begin
                    state_nx = rwu_set ? ST_SLEEP : ST_AWAKE;
                end
            end
            ST_AWAKE: begin
                if (!re) begin
                    state_nx = ST_OFF;
                end else if (rwu_set) begin
                    state_nx = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (!re) begin
                    state_nx = ST_OFF;
                end else if (wake_sel ? addr_hit : idle_hit) begin
                    state_nx = ST_AWAKE;
                end
            end
            default: state_nx = ST_OFF;
        endcase
    end

    always_comb begin
        sleeping = (state == ST_SLEEP);
        awake    = (state == ST_AWAKE);
        arm      = (state_nx == ST_SLEEP) && (state != ST_SLEEP);
    end
endmodule

// File: rtl/rxwk_flags.sv
module rxwk_flags #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic              accept,
    input  logic              idle_set,
    input  logic              rdrf_clr,
    input  logic              idle_clr,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_nf,
    input  logic              word_fe,
    output logic              rdrf,
    output logic              ovr,
    output logic              idle,
    output logic              nf,
    output logic              fe,
    output logic [DATA_W-1:0] rx_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdrf    <= 1'b0;
            ovr     <= 1'b0;
            idle    <= 1'b0;
            nf      <= 1'b0;
            fe      <= 1'b0;
            rx_data <= '0;
        end else if (!re) begin
            rdrf <= 1'b0;
            ovr  <= 1'b0;
            idle <= 1'b0;
            nf   <= 1'b0;
            fe   <= 1'b0;
        end else begin
            if (accept) begin
                if (rdrf && !rdrf_clr) begin
                    ovr <= 1'b1;
                end else begin
                    rdrf    <= 1'b1;
                    ovr     <= 1'b0;
                    rx_data <= word_data;
                    nf      <= word_nf;
                    fe      <= word_fe;
                end
            end else if (rdrf_clr) begin
                rdrf <= 1'b0;
                ovr  <= 1'b0;
                nf   <= 1'b0;
                fe   <= 1'b0;
            end
            if (idle_set) begin
                idle <= 1'b1;
            end else if (idle_clr) begin
                idle <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rxwk_ctrl.sv
module rxwk_ctrl #(
    parameter int DATA_W     = 9,
    parameter int SHORT_BITS = 10,
    parameter int LONG_BITS  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic              rwu_set,
    input  logic              wake_sel,
    input  logic              long_frame,
    input  logic              rie,
    input  logic              ilie,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              word_valid,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_nf,
    input  logic              word_fe,
    input  logic              rdrf_clr,
    input  logic              idle_clr,
    output logic              rx_pad_input,
    output logic              sleeping,
    output logic              rdrf,
    output logic              ovr,
    output logic              idle,
    output logic              nf,
    output logic              fe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_irq
);
    localparam int MSB_S = DATA_W - 2;
    localparam int MSB_L = DATA_W - 1;

    logic addr_mark;
    logic addr_hit;
    logic idle_hit;
    logic awake;
    logic arm;
    logic accept;

    assign addr_mark = long_frame ? word_data[MSB_L] : word_data[MSB_S];
    assign addr_hit  = word_valid && addr_mark;

    rxwk_idle_counter #(
        .SHORT_BITS (SHORT_BITS),
        .LONG_BITS  (LONG_BITS)
    ) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (!re || arm),
        .long_frame (long_frame),
        .bit_stb    (bit_stb),
        .bit_val    (bit_val),
        .full_hit   (idle_hit)
    );

    rxwk_sleep_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .re       (re),
        .rwu_set  (rwu_set),
        .wake_sel (wake_sel),
        .idle_hit (idle_hit),
        .addr_hit (addr_hit),
        .sleeping (sleeping),
        .awake    (awake),
        .arm      (arm)
    );

    assign accept = word_valid && (awake || (sleeping && wake_sel && addr_mark));

    rxwk_flags #(
        .DATA_W (DATA_W)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .re        (re),
        .accept    (accept),
        .idle_set  (idle_hit && awake),
        .rdrf_clr  (rdrf_clr),
        .idle_clr  (idle_clr),
        .word_data (word_data),
        .word_nf   (word_nf),
        .word_fe   (word_fe),
        .rdrf      (rdrf),
        .ovr       (ovr),
        .idle      (idle),
        .nf        (nf),
        .fe        (fe),
        .rx_data   (rx_data)
    );

    assign rx_pad_input = re;
    assign rx_irq       = (rie && (rdrf || ovr)) || (ilie && idle);
endmodule

// File: rtl/rxwk_checker.sv
module rxwk_checker (
    input logic clk,
    input logic rst_n,
    input logic re,
    input logic rwu_set,
    input logic wake_sel,
    input logic word_valid,
    input logic addr_mark,
    input logic rdrf_clr,
    input logic rdrf,
    input logic ovr,
    input logic idle,
    input logic nf,
    input logic fe,
    input logic sleeping
);
    assert_sleep_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (re && !sleeping && rwu_set) |=> sleeping);

    assert_addr_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (re && sleeping && wake_sel && word_valid && addr_mark) |=> (!sleeping && rdrf));

    assert_asleep_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (re && sleeping && !wake_sel && !rdrf) |=> !rdrf);

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> !(rdrf || ovr || idle || nf || fe || sleeping));

    assert_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (re && rdrf && !rdrf_clr && word_valid && !sleeping) |=> ovr);
endmodule

bind rxwk_ctrl rxwk_checker u_chk (.*);

// File: tb/rxwk_ctrl_bench.sv
module rxwk_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       re = 1'b0, rwu_set = 1'b0, wake_sel = 1'b0, long_frame = 1'b0;
    logic       rie = 1'b0, ilie = 1'b0, bit_stb = 1'b0, bit_val = 1'b1;
    logic       word_valid = 1'b0, word_nf = 1'b0, word_fe = 1'b0;
    logic [8:0] word_data = '0;
    logic       rdrf_clr = 1'b0, idle_clr = 1'b0;
    logic       rx_pad_input, sleeping, rdrf, ovr, idle, nf, fe, rx_irq;
    logic [8:0] rx_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxwk_ctrl u_rxwk_ctrl (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        bit_val = b; bit_stb = 1'b1;
        step();
        bit_stb = 1'b0;
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic send_word(input logic [8:0] d, input logic n, input logic f, input logic clr);
        word_data = d; word_nf = n; word_fe = f; word_valid = 1'b1; rdrf_clr = clr;
        step();
        word_valid = 1'b0; rdrf_clr = 1'b0; word_nf = 1'b0; word_fe = 1'b0;
    endtask

    task automatic pulse_rdrf_clr();
        rdrf_clr = 1'b1; step(); rdrf_clr = 1'b0;
    endtask

    task automatic pulse_idle_clr();
        idle_clr = 1'b1; step(); idle_clr = 1'b0;
    endtask

    task automatic pulse_sleep();
        rwu_set = 1'b1; step(); rwu_set = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9 reset rdrf", rdrf, 0);
        chk("R9 reset sleeping", sleeping, 0);
        chk("R1 pad off", rx_pad_input, 0);
        re = 1'b1; #1;
        chk("R1 pad on", rx_pad_input, 1);
        step();
    endtask

    task automatic t_receive();
        send_word(9'h041, 1'b1, 1'b0, 1'b0);
        chk("R2 rdrf", rdrf, 1);
        chk("R2 data", rx_data, 9'h041);
        chk("R2 nf", nf, 1);
        chk("R2 fe", fe, 0);
        send_word(9'h055, 1'b0, 1'b1, 1'b0);
        chk("R3 ovr", ovr, 1);
        chk("R3 data kept", rx_data, 9'h041);
        rie = 1'b1; #1;
        chk("R11 irq rie", rx_irq, 1);
        rie = 1'b0; #1;
        chk("R11 irq masked", rx_irq, 0);
        pulse_rdrf_clr();
        chk("R10 clr rdrf", rdrf, 0);
        chk("R10 clr ovr", ovr, 0);
        chk("R10 clr nf", nf, 0);
    endtask

    task automatic t_collision();
        send_word(9'h011, 1'b0, 1'b0, 1'b0);
        send_word(9'h022, 1'b0, 1'b1, 1'b1);
        chk("R10 collide rdrf", rdrf, 1);
        chk("R10 collide ovr", ovr, 0);
        chk("R10 collide data", rx_data, 9'h022);
        chk("R10 collide fe", fe, 1);
        pulse_rdrf_clr();
    endtask

    task automatic t_idle();
        long_frame = 1'b0;
        send_bit(1'b0);
        send_ones(9);
        chk("R4 idle early M0", idle, 0);
        send_ones(1);
        chk("R4 idle M0", idle, 1);
        ilie = 1'b1; #1;
        chk("R11 irq idle", rx_irq, 1);
        ilie = 1'b0;
        pulse_idle_clr();
        chk("R10 idle clr", idle, 0);
        send_ones(3);
        chk("R4 saturate", idle, 0);
        long_frame = 1'b1;
        send_bit(1'b0);
        send_ones(10);
        chk("R4 idle early M1", idle, 0);
        send_ones(1);
        chk("R4 idle M1", idle, 1);
        pulse_idle_clr();
        long_frame = 1'b0;
        send_bit(1'b0);
        send_ones(5);
        send_bit(1'b0);
        send_ones(9);
        chk("R4 zero restarts", idle, 0);
        send_ones(1);
        chk("R4 idle after restart", idle, 1);
        pulse_idle_clr();
    endtask

    task automatic t_idle_wake();
        wake_sel = 1'b0; long_frame = 1'b0;
        send_bit(1'b0);
        send_ones(5);
        pulse_sleep();
        chk("R5 sleep entry", sleeping, 1);
        send_word(9'h0FF, 1'b0, 1'b0, 1'b0);
        chk("R8 asleep no load", rdrf, 0);
        chk("R8 asleep stays", sleeping, 1);
        send_ones(9);
        chk("R5 count restarted", sleeping, 1);
        send_ones(1);
        chk("R6 idle wake", sleeping, 0);
        chk("R6 no idle flag", idle, 0);
    endtask

    task automatic t_addr_wake();
        wake_sel = 1'b1; long_frame = 1'b0;
        pulse_sleep();
        chk("R5 sleep addr", sleeping, 1);
        send_word(9'h07F, 1'b0, 1'b0, 1'b0);
        chk("R8 unmarked rdrf", rdrf, 0);
        send_word(9'h100, 1'b0, 1'b0, 1'b0);
        chk("R7 bit8 ignored M0", sleeping, 1);
        send_bit(1'b0);
        send_ones(12);
        chk("R8 no idle asleep", idle, 0);
        chk("R8 idle no wake", sleeping, 1);
        send_word(9'h080, 1'b0, 1'b0, 1'b0);
        chk("R7 wake M0", sleeping, 0);
        chk("R7 load rdrf", rdrf, 1);
        chk("R7 load data", rx_data, 9'h080);
        pulse_rdrf_clr();
        long_frame = 1'b1;
        pulse_sleep();
        send_word(9'h080, 1'b0, 1'b0, 1'b0);
        chk("R7 bit7 ignored M1", sleeping, 1);
        chk("R8 rdrf M1", rdrf, 0);
        send_word(9'h100, 1'b0, 1'b0, 1'b0);
        chk("R7 wake M1", sleeping, 0);
        chk("R7 data M1", rx_data, 9'h100);
        pulse_rdrf_clr();
        long_frame = 1'b0; wake_sel = 1'b0;
    endtask

    task automatic t_disable();
        send_word(9'h033, 1'b1, 1'b1, 1'b0);
        pulse_sleep();
        re = 1'b0;
        step();
        chk("R9 rdrf off", rdrf, 0);
        chk("R9 nf off", nf, 0);
        chk("R9 sleep off", sleeping, 0);
        chk("R1 pad off", rx_pad_input, 0);
        send_word(9'h044, 1'b0, 1'b0, 1'b0);
        chk("R9 word ignored", rdrf, 0);
        re = 1'b1;
        step();
    endtask

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_receive();
        t_collision();
        t_idle();
        t_idle_wake();
        t_addr_wake();
        t_disable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule